// File: doc/BRIEF.md
# Vectored interrupt controller

This block collects up to 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt request (`irq_o`) and a fast one (`fiq_o`). Each line has its own configuration word with three fields:

- a 5-bit urgency value;
- a sensitivity choice, either edge or level;
- a routing choice that picks one of the two outputs.

A 32-bit pending vector records requests. A mask register holds back individual lines. Two independent arbiters choose the most urgent unmasked line for each output.

When an arbiter is armed and it has a candidate, its output goes high. The chosen line number is frozen in a code register and the arbiter disarms. Software reads the code to learn which line to service. That read also retires the request if the line is edge-sensitive. Software then writes the control register to drop the output and arm a fresh arbitration. A software-trigger register lets firmware raise a line without a hardware event.

The register port is a simple single-cycle bus. Writes take effect at the clock edge. Read data is a combinational function of the address and the current state. A read's side effect happens at the edge that ends the access.

Top module: `vec_intc`

## Requirements
- R1: After reset the pending vector reads 0, the mask reads all ones, every line configuration reads 0, both code registers read 0, and `irq_o` and `fiq_o` are low.
- R2: The configuration word of line n is at byte offset 0x1C+4n. It holds the urgency in bits [6:2], the sensitivity in bit 1 (0 = edge, 1 = level) and the routing in bit 0 (1 = fast output). These fields read back as written, and all other bits read 0.
- R3: An edge-sensitive line becomes pending only at a low-to-high change of its input, sampled at the clock. Its pending bit remains set after the input returns low.
- R4: A level-sensitive line is pending in every cycle its input is high. Its pending bit clears at the clock edge after the input goes from high to low.
- R5: A write to the pending vector (offset 0x00) ANDs each pending bit with the written bit. A level-sensitive line whose input is high keeps its pending bit.
- R6: The mask register (offset 0x04, 1 = masked) reads back as written. A masked line never causes either output to assert.
- R7: An output rises at the clock edge that ends a cycle in which its arbiter is armed and an unmasked pending line is routed to it. At that edge the winner is latched and the arbiter disarms. Until acknowledged, the output stays high and the code stays unchanged, even if more urgent lines arrive.
- R8: The winner has the numerically smallest urgency value (0 is the most urgent). Among equal values, the highest line number wins.
- R9: Reading the normal code (offset 0x10) or the fast code (offset 0x14) returns the latched line number. If that line is edge-sensitive, the read also clears its pending bit.
- R10: Writing the control register (offset 0x18) with bit 0 set drops `irq_o` at that edge and arms the normal arbiter. Bit 1 does the same for `fiq_o`. The control register reads 0.
- R11: Writing offset 0x9C makes only the line of the lowest set bit in the written value pending. The offset reads 0.
- R12: A read of any other offset returns 0, and a write to it changes no state.
- R13: Lines routed to the fast output never assert `irq_o`. Lines routed to the normal output never assert `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Interrupt request inputs, active high |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The bound checker watches every cycle for these properties:

- An output rises only when a candidate routed to it was unmasked and pending one cycle earlier.
- The latched code names one of those candidates.
- An acknowledge drops the output at the next edge.
- An unacknowledged output holds both its level and its code.

Some behaviour depends on configuration history or on a read's side effect, so only the bench scenarios can show it:

- that the tie-break selects the highest-numbered line;
- that a code read retires only edge-sensitive requests;
- the AND rule for pending writes, including its exception for held level inputs;
- the lowest-bit rule of the software trigger;
- that undefined offsets have no effect.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // Register byte offsets (the per-line block is decoded arithmetically)
   localparam int unsigned OFS_PEND = 32'h00;
   localparam int unsigned OFS_MASK = 32'h04;
   localparam int unsigned OFS_IRQC = 32'h10;
   localparam int unsigned OFS_FIQC = 32'h14;
   localparam int unsigned OFS_CTL  = 32'h18;
   localparam int unsigned OFS_CFG0 = 32'h1C;
   localparam int unsigned OFS_SWT  = 32'h9C;

   // Width of the per-line urgency field, bits [6:2] of a configuration word
   localparam int unsigned PRIO_W = 5;

   // Output channel index
   typedef enum logic {
      CH_IRQ = 1'b0,
      CH_FIQ = 1'b1
   } chan_e;
endpackage

// File: rtl/vic_pending.sv
// Per-line request capture: edge/level detection, software set and clear paths.
module vic_pending #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line_in,
   input  logic [N-1:0] level_mode,
   input  logic         and_wr,
   input  logic [N-1:0] and_val,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] rd_clr,
   output logic [N-1:0] pend_q
);
   logic [N-1:0] in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q <= '0;
      else        in_q <= line_in;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      logic rise, fall, held, set_i, clr_i;
      assign rise  = line_in[i] & ~in_q[i];
      assign fall  = ~line_in[i] & in_q[i];
      assign held  = level_mode[i] & line_in[i];
      assign set_i = (level_mode[i] ? line_in[i] : rise) | sw_set[i];
      assign clr_i = (level_mode[i] & fall)
                   | (and_wr & ~and_val[i] & ~held)
                   | rd_clr[i];

      // a new request in the same cycle as a clear is never lost
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pend_q[i] <= 1'b0;
         else if (set_i) pend_q[i] <= 1'b1;
         else if (clr_i) pend_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/vic_arbiter.sv
// Combinational winner search: smallest urgency value, ties to the highest index.
module vic_arbiter #(
   parameter int N      = 32,
   parameter int PRIO_W = 5,
   parameter int IDX_W  = 5
) (
   input  logic [N-1:0]             cand,
   input  logic [N-1:0][PRIO_W-1:0] prio,
   output logic                     any,
   output logic [IDX_W-1:0]         win
);
   logic [PRIO_W-1:0] best;

   always_comb begin
      any  = 1'b0;
      best = '1;
      win  = '0;
      for (int i = 0; i < N; i++) begin
         if (cand[i] && (!any || prio[i] <= best)) begin
            any  = 1'b1;
            best = prio[i];
            win  = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vic_gate.sv
// One output channel: arm flag, output flop and frozen winner code.
module vic_gate #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any,
   input  logic [IDX_W-1:0] win,
   input  logic             ack,
   output logic             out_q,
   output logic [IDX_W-1:0] code_q
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         out_q   <= 1'b0;
         code_q  <= '0;
      end else if (ack) begin
         armed_q <= 1'b1;
         out_q   <= 1'b0;
      end else if (armed_q && any) begin
         armed_q <= 1'b0;
         out_q   <= 1'b1;
         code_q  <= win;
      end
   end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import vic_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_in,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq_o,
   output logic                 fiq_o
);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int N     = NUM_LINES;
   localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_IRQC = ADDR_W'(OFS_IRQC);
   localparam logic [ADDR_W-1:0] A_FIQC = ADDR_W'(OFS_FIQC);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_SWT  = ADDR_W'(OFS_SWT);
   localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(OFS_CFG0);
   localparam logic [ADDR_W-1:0] A_CFGL = ADDR_W'(OFS_CFG0 + 4 * (N - 1));

   // elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data
      $error("vec_intc: DATA_W must be 32");
   end
   if (N < 2 || N > 32) begin : g_bad_lines
      $error("vec_intc: NUM_LINES must lie in 2..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("vec_intc: ADDR_W must be at least 8");
   end

   logic wr, rd, cfg_hit;
   logic [IDX_W-1:0] cfg_idx;
   assign wr      = bus_sel & bus_wr;
   assign rd      = bus_sel & ~bus_wr;
   assign cfg_hit = (bus_addr >= A_CFG0) && (bus_addr <= A_CFGL) && (bus_addr[1:0] == 2'b00);
   assign cfg_idx = IDX_W'((bus_addr - A_CFG0) >> 2);

   // configuration state
   logic [N-1:0][PRIO_W-1:0] prio_q;
   logic [N-1:0]             level_q, fiq_q, mask_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q  <= '0;
         level_q <= '0;
         fiq_q   <= '0;
         mask_q  <= '1;
      end else begin
         if (wr && bus_addr == A_MASK) mask_q <= bus_wdata[N-1:0];
         if (wr && cfg_hit) begin
            prio_q[cfg_idx]  <= bus_wdata[PRIO_W+1:2];
            level_q[cfg_idx] <= bus_wdata[1];
            fiq_q[cfg_idx]   <= bus_wdata[0];
         end
      end
   end

   // software trigger keeps only the lowest set bit
   logic [N-1:0] sw_vec, sw_set;
   assign sw_vec = bus_wdata[N-1:0];
   assign sw_set = (wr && bus_addr == A_SWT) ? (sw_vec & (~sw_vec + N'(1))) : '0;

   // output channels
   logic [IDX_W-1:0] code_q [2];
   logic [IDX_W-1:0] win    [2];
   logic [N-1:0]     cand   [2];
   logic             any    [2];
   logic             ack    [2];
   logic             out_q  [2];

   // reading a code retires the named line when it is edge-sensitive
   logic [N-1:0] rd_clr;
   always_comb begin
      rd_clr = '0;
      if (rd && bus_addr == A_IRQC) rd_clr |= (N'(1) << code_q[CH_IRQ]) & ~level_q;
      if (rd && bus_addr == A_FIQC) rd_clr |= (N'(1) << code_q[CH_FIQ]) & ~level_q;
   end

   vic_pending #(.N(N)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (line_in),
      .level_mode (level_q),
      .and_wr     (wr && bus_addr == A_PEND),
      .and_val    (bus_wdata[N-1:0]),
      .sw_set     (sw_set),
      .rd_clr     (rd_clr),
      .pend_q     (pend_q)
   );

   for (genvar k = 0; k < 2; k++) begin : g_chan
      assign cand[k] = pend_q & ~mask_q & ((k == int'(CH_FIQ)) ? fiq_q : ~fiq_q);
      assign ack[k]  = wr && (bus_addr == A_CTL) && bus_wdata[k];

      vic_arbiter #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
         .cand (cand[k]),
         .prio (prio_q),
         .any  (any[k]),
         .win  (win[k])
      );

      vic_gate #(.IDX_W(IDX_W)) u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .any    (any[k]),
         .win    (win[k]),
         .ack    (ack[k]),
         .out_q  (out_q[k]),
         .code_q (code_q[k])
      );
   end

   assign irq_o = out_q[CH_IRQ];
   assign fiq_o = out_q[CH_FIQ];

   // read mux; control, trigger and undefined offsets read 0
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_PEND)      bus_rdata = DATA_W'(pend_q);
      else if (bus_addr == A_MASK) bus_rdata = DATA_W'(mask_q);
      else if (bus_addr == A_IRQC) bus_rdata = DATA_W'(code_q[CH_IRQ]);
      else if (bus_addr == A_FIQC) bus_rdata = DATA_W'(code_q[CH_FIQ]);
      else if (cfg_hit)
         bus_rdata = DATA_W'({prio_q[cfg_idx], level_q[cfg_idx], fiq_q[cfg_idx]});
   end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
   parameter int N      = 32,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_o,
   input logic              fiq_o,
   input logic [N-1:0]      pend,
   input logic [N-1:0]      mask,
   input logic [N-1:0]      route,
   input logic [IDX_W-1:0]  irq_code,
   input logic [IDX_W-1:0]  fiq_code
);
   logic [N-1:0] cand_irq, cand_fiq;
   logic         ctl_wr, ack_irq, ack_fiq;
   assign cand_irq = pend & ~mask & ~route;
   assign cand_fiq = pend & ~mask & route;
   assign ctl_wr   = bus_sel && bus_wr && (bus_addr == ADDR_W'(vic_pkg::OFS_CTL));
   assign ack_irq  = ctl_wr && bus_wdata[0];
   assign ack_fiq  = ctl_wr && bus_wdata[1];

   // R7
   irq_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|cand_irq));
   // R13
   fiq_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fiq_o) |-> $past(|cand_fiq));
   // R8
   irq_winner_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> |($past(cand_irq) & (N'(1) << irq_code)));
   // R8
   fiq_winner_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fiq_o) |-> |($past(cand_fiq) & (N'(1) << fiq_code)));
   // R10
   irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_irq |=> !irq_o);
   // R10
   fiq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fiq |=> !fiq_o);
   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_irq) |=> (irq_o && $stable(irq_code)));
   // R7
   fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_o && !ack_fiq) |=> (fiq_o && $stable(fiq_code)));
endmodule

bind vec_intc vec_intc_chk #(
   .N(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .pend      (pend_q),
   .mask      (mask_q),
   .route     (fiq_q),
   .irq_code  (code_q[0]),
   .fiq_code  (code_q[1])
);

// File: tb/tb_vec_intc.sv
`timescale 1ns/1ps
module tb_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] line_in = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, fiq_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;
   int rp [32];
   int rr [32];

   always #2.5 clk = ~clk;

   vec_intc dut (
      .clk(clk), .rst_n(rst_n), .line_in(line_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_lines(input logic [31:0] v);
      @(negedge clk);
      line_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clean();
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'h0);
      bus_write(8'h18, 32'h3);
   endtask

   // expected winner from the R8 rule, using the bench's copy of urgencies
   function automatic int pick(input logic [31:0] c);
      int b = -1;
      int bp = 1000;
      for (int i = 0; i < 32; i++)
         if (c[i] && rp[i] <= bp) begin
            bp = rp[i];
            b = i;
         end
      return b;
   endfunction

   function automatic logic [31:0] cfg_addr(input int n);
      return 32'h1C + 32'(4 * n);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] vec, m, route;
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_o", 32'(irq_o), 32'h0);
      chk("R1 fiq_o", 32'(fiq_o), 32'h0);
      bus_read(8'h00, d); chk("R1 pending", d, 32'h0);
      bus_read(8'h04, d); chk("R1 mask", d, 32'hFFFF_FFFF);
      bus_read(8'h10, d); chk("R1 irq code", d, 32'h0);
      bus_read(8'h14, d); chk("R1 fiq code", d, 32'h0);
      bus_read(8'h30, d); chk("R1 cfg line 5", d, 32'h0);

      // R2 configuration fields
      bus_write(8'h38, 32'hFFFF_FFFF);
      bus_read(8'h38, d); chk("R2 cfg line 7 all ones", d, 32'h7F);
      bus_write(8'h98, 32'h55);
      bus_read(8'h98, d); chk("R2 cfg line 31", d, 32'h55);
      bus_write(8'h38, 32'h0);
      bus_write(8'h98, 32'h0);

      // R3 edge capture, stays after input falls, no capture of a held input
      set_lines(32'h8); set_lines(32'h0);
      bus_read(8'h00, d); chk("R3 edge pulse latched", d, 32'h8);
      set_lines(32'h40);
      bus_write(8'h00, 32'h0);
      bus_read(8'h00, d); chk("R3 held edge input not re-latched", d, 32'h0);
      set_lines(32'h0);

      // R4 / R5 level behaviour
      bus_write(8'h40, 32'h2);
      set_lines(32'h200);
      bus_read(8'h00, d); chk("R4 level pending", d, 32'h200);
      bus_write(8'h00, 32'h0);
      bus_read(8'h00, d); chk("R5 held level survives AND write", d, 32'h200);
      set_lines(32'h0);
      bus_read(8'h00, d); chk("R4 level clears on fall", d, 32'h0);

      // R7 / R8 / R9 / R10 arbitration and acknowledge
      bus_write(8'h24, 32'hC);   // line 2, urgency 3
      bus_write(8'h44, 32'h4);   // line 10, urgency 1
      bus_write(8'h6C, 32'h4);   // line 20, urgency 1
      set_lines(32'h0010_0404); set_lines(32'h0);
      bus_write(8'h04, 32'h0);
      idle(1);
      chk("R7 irq asserts", 32'(irq_o), 32'h1);
      chk("R13 fiq stays low", 32'(fiq_o), 32'h0);
      bus_read(8'h10, d); chk("R8 tie goes to highest line", d, 32'd20);
      bus_read(8'h00, d); chk("R9 code read retires edge line", d, 32'h0000_0404);
      set_lines(32'h0200_0000); set_lines(32'h0);   // line 25, urgency 0
      bus_read(8'h10, d); chk("R7 code frozen until ack", d, 32'd20);
      chk("R7 irq held", 32'(irq_o), 32'h1);
      bus_write(8'h18, 32'h1);
      chk("R10 ack drops irq", 32'(irq_o), 32'h0);
      idle(1);
      chk("R10 re-arbitration asserts", 32'(irq_o), 32'h1);
      bus_read(8'h10, d); chk("R8 most urgent wins", d, 32'd25);
      bus_read(8'h18, d); chk("R10 control reads 0", d, 32'h0);
      clean();

      // R13 fast routing
      bus_write(8'h4C, 32'h9);   // line 12, urgency 2, fast
      set_lines(32'h1000); set_lines(32'h0);
      bus_write(8'h04, 32'h0);
      idle(1);
      chk("R13 fiq asserts", 32'(fiq_o), 32'h1);
      chk("R13 irq stays low", 32'(irq_o), 32'h0);
      bus_read(8'h14, d); chk("R9 fiq code", d, 32'd12);
      bus_write(8'h18, 32'h2);
      chk("R10 ack drops fiq", 32'(fiq_o), 32'h0);
      idle(2);
      chk("R9 retired line does not re-fire", 32'(fiq_o), 32'h0);
      bus_write(8'h04, 32'hFFFF_FFFF);

      // R11 software trigger
      bus_write(8'h9C, 32'hA0);
      bus_read(8'h00, d); chk("R11 lowest bit only", d, 32'h20);
      bus_read(8'h9C, d); chk("R11 trigger reads 0", d, 32'h0);

      // R12 undefined offsets
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_write(8'hA0, 32'hFFFF_FFFF);
      bus_write(8'h1E, 32'hFFFF_FFFF);
      bus_read(8'h00, d); chk("R12 pending untouched", d, 32'h20);
      bus_read(8'h04, d); chk("R12 mask untouched", d, 32'hFFFF_FFFF);
      bus_read(8'h1C, d); chk("R12 cfg line 0 untouched", d, 32'h0);
      bus_read(8'h08, d); chk("R12 read 0x08", d, 32'h0);
      bus_read(8'hA0, d); chk("R12 read 0xA0", d, 32'h0);

      // R6 masking
      bus_write(8'h04, ~32'h80);
      idle(2);
      chk("R6 masked pending line stays quiet", 32'(irq_o), 32'h0);
      bus_write(8'h04, ~32'h20);
      bus_read(8'h04, d); chk("R6 mask readback", d, ~32'h20);
      chk("R6 unmasked line asserts", 32'(irq_o), 32'h1);
      bus_read(8'h10, d); chk("R6 code", d, 32'd5);
      clean();
      bus_write(8'h40, 32'h0);

      // constrained random: edge lines, few urgency levels to force ties
      void'($urandom(32'd2024));
      for (int it = 0; it < 30; it++) begin
         clean();
         route = '0;
         for (int i = 0; i < 32; i++) begin
            rp[i] = int'($urandom % 4);
            rr[i] = int'($urandom % 2);
            route[i] = rr[i][0];
            bus_write(8'(cfg_addr(i)), 32'((rp[i] << 2) | rr[i]));
         end
         vec = $urandom;
         m   = $urandom & $urandom;
         set_lines(vec); set_lines(32'h0);
         bus_read(8'h00, d); chk("R3 random capture", d, vec);
         bus_write(8'h04, m);
         idle(1);
         chk("R7 random irq level", 32'(irq_o), 32'(|(vec & ~m & ~route)));
         chk("R13 random fiq level", 32'(fiq_o), 32'(|(vec & ~m & route)));
         if (|(vec & ~m & ~route)) begin
            w = pick(vec & ~m & ~route);
            bus_read(8'h10, d); chk("R8 random irq winner", d, 32'(w));
         end
         if (|(vec & ~m & route)) begin
            w = pick(vec & ~m & route);
            bus_read(8'h14, d); chk("R8 random fiq winner", d, 32'(w));
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule